// File: doc/BRIEF.md
# Multi-Channel DMA Register Window Decoder

This block is the address decoder at the front of a multi-channel DMA engine. It takes 32-bit word accesses from two bus windows and steers each one either to a per-channel register set or to the two global registers it holds itself. The main window is 4 KB wide. Its lower part is split into 256-byte slices, one per channel. Its upper part holds a per-channel interrupt status word and a per-channel enable word. A second 256-byte window belongs to the highest-numbered channel alone. That channel has no slice in the main window.

Channel register sets sit outside this block. The decoder gives them a one-hot select, a write strobe, an 8-bit register offset and the write data in the same cycle as the bus access. One cycle later it returns the selected channel's read data on the window that asked for it. The channels report interrupt set and clear events to the decoder. The decoder keeps the status word from these events and drives one interrupt output per channel from it. The enable word is driven to the channels.

Top module: `dma_reg_decoder`

## Requirements
- R1: On the main window, an offset below 0xF00 selects channel offset[11:8]. In that cycle the block raises only that bit of `chSel`, drives offset[7:0] on `chRegOff`, and passes the write strobe and write data to the channel.
- R2: A read returns data on the requesting window's read-data port one clock after the access. For a channel access this is the selected channel's slice of `chRdata`.
- R3: Every access on the secondary window goes to channel 15 with offset[7:0]. This includes offsets such as 0xF0. The secondary window never touches the global registers.
- R4: Main offset 0xFF0 is the enable word. A write stores wdata[15:0], and `chEnable` shows the new value one cycle later. A read returns the stored value in bits 15:0 with bits 31:16 zero.
- R5: A read of main offset 0xFE0 returns the interrupt status in bits 15:0 with bits 31:16 zero. A write to 0xFE0 changes nothing.
- R6: After reset, `chEnable` is 0xFFFF, the interrupt status and `irqOut` are zero, and both read-data ports are zero.
- R7: Bit n of the status is set one cycle after `chIrqSet[n]` and cleared one cycle after `chIrqClr[n]`. When both are high in the same cycle, the set wins. `irqOut` equals the status word.
- R8: Any other main offset at or above 0xF00 selects no channel, reads as zero and ignores writes.
- R9: When both windows are accessed in the same cycle, the main window is served. The secondary access selects no channel and leaves `altRdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mainSel | input | 1 | Main window access valid |
| mainWr | input | 1 | Main window write (1) or read (0) |
| mainAddr | input | 12 | Main window byte offset |
| mainWdata | input | 32 | Main window write data |
| mainRdata | output | 32 | Main window read data, one cycle after the read |
| altSel | input | 1 | Secondary window access valid |
| altWr | input | 1 | Secondary window write (1) or read (0) |
| altAddr | input | 8 | Secondary window byte offset |
| altWdata | input | 32 | Secondary window write data |
| altRdata | output | 32 | Secondary window read data, one cycle after the read |
| chSel | output | 16 | One-hot channel select |
| chWr | output | 1 | Write strobe to the selected channel |
| chRegOff | output | 8 | Register offset within the selected channel |
| chWdata | output | 32 | Write data to the selected channel |
| chRdata | input | 512 | Read data of all channels, channel n in bits 32n+31:32n |
| chIrqSet | input | 16 | Per-channel interrupt raise event |
| chIrqClr | input | 16 | Per-channel interrupt clear event |
| irqOut | output | 16 | Per-channel interrupt lines |
| chEnable | output | 16 | Per-channel global enable |

## Verification
Two cases are hard to reach from the ports. The first is a collision, where both windows are accessed in the same cycle. The bench drives a main read and a secondary read together. It checks that only the main channel is selected and that the secondary read-data port keeps the value from an earlier secondary read. The second case is the set/clear race on one status bit, which the bench creates by pulsing both event inputs for the same channel together. The bench also reaches channel 15 through the secondary window at offset 0xF0. It checks that the enable word is untouched, because that offset would decode as a global register on the main window.

// File: rtl/dma_dec_pkg.sv
package dma_dec_pkg;

  // Strobes passed from the decode control to the register datapath
  typedef struct packed {
    logic mainRd;   // main window read this cycle
    logic altRd;    // secondary window read this cycle
    logic chanHit;  // a channel is the target
    logic enWr;     // write of the enable word
    logic enRd;     // read of the enable word
    logic statRd;   // read of the interrupt status word
  } decStrobe_t;

endpackage

// File: rtl/dma_dec_ctrl.sv
module dma_dec_ctrl
  import dma_dec_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int DW         = 32,
  parameter int MAIN_AW    = 12,
  parameter int REG_AW     = 8,
  parameter int CH_LIMIT   = 'hF00,
  parameter int STATUS_OFF = 'hFE0,
  parameter int ENABLE_OFF = 'hFF0,
  localparam int CW        = $clog2(NUM_CH)
) (
  input  logic               mainSel,
  input  logic               mainWr,
  input  logic [MAIN_AW-1:0] mainAddr,
  input  logic [DW-1:0]      mainWdata,
  input  logic               altSel,
  input  logic               altWr,
  input  logic [REG_AW-1:0]  altAddr,
  input  logic [DW-1:0]      altWdata,
  output decStrobe_t         strobes,
  output logic [CW-1:0]      chanIdx,
  output logic [NUM_CH-1:0]  chSel,
  output logic               chWr,
  output logic [REG_AW-1:0]  chRegOff,
  output logic [DW-1:0]      chWdata
);

  logic mainGo, altGo, mainChan, mainGlob;

  // The main window always wins a collision
  assign mainGo   = mainSel;
  assign altGo    = altSel & ~mainSel;
  assign mainChan = mainGo && (int'(mainAddr) < CH_LIMIT);
  assign mainGlob = mainGo && !mainChan;

  always_comb begin
    strobes         = '0;
    strobes.mainRd  = mainGo & ~mainWr;
    strobes.altRd   = altGo & ~altWr;
    strobes.chanHit = mainChan | altGo;
    strobes.enWr    = mainGlob &  mainWr && (int'(mainAddr) == ENABLE_OFF);
    strobes.enRd    = mainGlob & ~mainWr && (int'(mainAddr) == ENABLE_OFF);
    strobes.statRd  = mainGlob & ~mainWr && (int'(mainAddr) == STATUS_OFF);
  end

  always_comb begin
    if (altGo) begin
      chanIdx  = CW'(NUM_CH - 1);
      chRegOff = altAddr;
      chWdata  = altWdata;
      chWr     = altWr;
    end else begin
      chanIdx  = mainAddr[REG_AW +: CW];
      chRegOff = mainAddr[REG_AW-1:0];
      chWdata  = mainWdata;
      chWr     = mainChan & mainWr;
    end
  end

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_sel
    assign chSel[gi] = strobes.chanHit && (chanIdx == CW'(gi));
  end

endmodule

// File: rtl/dma_dec_dp.sv
module dma_dec_dp
  import dma_dec_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DW     = 32,
  localparam int CW    = $clog2(NUM_CH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  decStrobe_t         strobes,
  input  logic [CW-1:0]      chanIdx,
  input  logic [DW-1:0]      mainWdata,
  input  logic [NUM_CH*DW-1:0] chRdata,
  input  logic [NUM_CH-1:0]  chIrqSet,
  input  logic [NUM_CH-1:0]  chIrqClr,
  output logic [DW-1:0]      mainRdata,
  output logic [DW-1:0]      altRdata,
  output logic [NUM_CH-1:0]  irqOut,
  output logic [NUM_CH-1:0]  chEnable
);

  logic [NUM_CH-1:0] enableQ, statusQ;
  logic [DW-1:0]     rdMux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            enableQ <= '1;
    else if (strobes.enWr) enableQ <= mainWdata[NUM_CH-1:0];
  end

  // set has priority over clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) statusQ <= '0;
    else        statusQ <= (statusQ & ~chIrqClr) | chIrqSet;
  end

  always_comb begin
    rdMux = '0;
    if (strobes.chanHit)     rdMux = chRdata[chanIdx*DW +: DW];
    else if (strobes.enRd)   rdMux = DW'(enableQ);
    else if (strobes.statRd) rdMux = DW'(statusQ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mainRdata <= '0;
      altRdata  <= '0;
    end else begin
      if (strobes.mainRd) mainRdata <= rdMux;
      if (strobes.altRd)  altRdata  <= rdMux;
    end
  end

  assign irqOut   = statusQ;
  assign chEnable = enableQ;

endmodule

// File: rtl/dma_reg_decoder.sv
module dma_reg_decoder
  import dma_dec_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int DW         = 32,
  parameter int MAIN_AW    = 12,
  parameter int REG_AW     = 8,
  parameter int CH_LIMIT   = 'hF00,
  parameter int STATUS_OFF = 'hFE0,
  parameter int ENABLE_OFF = 'hFF0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mainSel,
  input  logic                 mainWr,
  input  logic [MAIN_AW-1:0]   mainAddr,
  input  logic [DW-1:0]        mainWdata,
  output logic [DW-1:0]        mainRdata,
  input  logic                 altSel,
  input  logic                 altWr,
  input  logic [REG_AW-1:0]    altAddr,
  input  logic [DW-1:0]        altWdata,
  output logic [DW-1:0]        altRdata,
  output logic [NUM_CH-1:0]    chSel,
  output logic                 chWr,
  output logic [REG_AW-1:0]    chRegOff,
  output logic [DW-1:0]        chWdata,
  input  logic [NUM_CH*DW-1:0] chRdata,
  input  logic [NUM_CH-1:0]    chIrqSet,
  input  logic [NUM_CH-1:0]    chIrqClr,
  output logic [NUM_CH-1:0]    irqOut,
  output logic [NUM_CH-1:0]    chEnable
);

  localparam int CW = $clog2(NUM_CH);

  decStrobe_t    strobes;
  logic [CW-1:0] chanIdx;

  dma_dec_ctrl #(
    .NUM_CH(NUM_CH), .DW(DW), .MAIN_AW(MAIN_AW), .REG_AW(REG_AW),
    .CH_LIMIT(CH_LIMIT), .STATUS_OFF(STATUS_OFF), .ENABLE_OFF(ENABLE_OFF)
  ) u_ctrl (
    .mainSel(mainSel), .mainWr(mainWr), .mainAddr(mainAddr), .mainWdata(mainWdata),
    .altSel(altSel), .altWr(altWr), .altAddr(altAddr), .altWdata(altWdata),
    .strobes(strobes), .chanIdx(chanIdx), .chSel(chSel), .chWr(chWr),
    .chRegOff(chRegOff), .chWdata(chWdata)
  );

  dma_dec_dp #(.NUM_CH(NUM_CH), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .chanIdx(chanIdx),
    .mainWdata(mainWdata), .chRdata(chRdata), .chIrqSet(chIrqSet),
    .chIrqClr(chIrqClr), .mainRdata(mainRdata), .altRdata(altRdata),
    .irqOut(irqOut), .chEnable(chEnable)
  );

endmodule

// File: rtl/dma_reg_decoder_chk.sv
module dma_reg_decoder_chk #(
  parameter int NUM_CH     = 16,
  parameter int DW         = 32,
  parameter int MAIN_AW    = 12,
  parameter int STATUS_OFF = 'hFE0,
  parameter int ENABLE_OFF = 'hFF0,
  parameter int CH_LIMIT   = 'hF00
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mainSel,
  input logic               mainWr,
  input logic [MAIN_AW-1:0] mainAddr,
  input logic [DW-1:0]      mainWdata,
  input logic               altSel,
  input logic               altWr,
  input logic [DW-1:0]      altRdata,
  input logic [NUM_CH-1:0]  chSel,
  input logic [NUM_CH-1:0]  chIrqSet,
  input logic [NUM_CH-1:0]  chIrqClr,
  input logic [NUM_CH-1:0]  irqOut,
  input logic [NUM_CH-1:0]  chEnable
);

  p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chSel));

  p_global_nosel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mainSel && int'(mainAddr) >= CH_LIMIT) |-> (chSel == '0));

  p_alt_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (altSel && !mainSel) |-> chSel[NUM_CH-1]);

  p_en_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mainSel && mainWr && int'(mainAddr) == ENABLE_OFF)
      |=> (chEnable == $past(mainWdata[NUM_CH-1:0])));

  p_status_wr_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mainSel && mainWr && int'(mainAddr) == STATUS_OFF && chIrqSet == '0 && chIrqClr == '0)
      |=> $stable(irqOut));

  p_alt_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mainSel && altSel) |=> $stable(altRdata));

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_irq
    p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      chIrqSet[gi] |=> irqOut[gi]);
    p_irq_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (chIrqClr[gi] && !chIrqSet[gi]) |=> !irqOut[gi]);
    p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!chIrqSet[gi] && !chIrqClr[gi]) |=> $stable(irqOut[gi]));
  end

endmodule

bind dma_reg_decoder dma_reg_decoder_chk #(
  .NUM_CH(NUM_CH), .DW(DW), .MAIN_AW(MAIN_AW),
  .STATUS_OFF(STATUS_OFF), .ENABLE_OFF(ENABLE_OFF), .CH_LIMIT(CH_LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mainSel(mainSel), .mainWr(mainWr),
  .mainAddr(mainAddr), .mainWdata(mainWdata), .altSel(altSel), .altWr(altWr),
  .altRdata(altRdata), .chSel(chSel), .chIrqSet(chIrqSet), .chIrqClr(chIrqClr),
  .irqOut(irqOut), .chEnable(chEnable)
);

// File: tb/dma_reg_decoder_bench.sv
module dma_reg_decoder_bench;

  localparam int NCH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mainSel = 0, mainWr = 0, altSel = 0, altWr = 0;
  logic [11:0] mainAddr = '0;
  logic [7:0]  altAddr = '0;
  logic [31:0] mainWdata = '0, altWdata = '0;
  logic [31:0] mainRdata, altRdata, chWdata;
  logic [NCH-1:0] chSel, irqOut, chEnable;
  logic [NCH-1:0] chIrqSet = '0, chIrqClr = '0;
  logic chWr;
  logic [7:0] chRegOff;
  logic [NCH*32-1:0] chRdata;

  int nTests = 0, nFail = 0, cycles = 0;

  always #2.5 clk = ~clk;

  // channel model: tag, channel number and the offset it was given
  always_comb
    for (int i = 0; i < NCH; i++)
      chRdata[i*32 +: 32] = {4'hA, 4'(i), 16'h0, chRegOff};

  dma_reg_decoder u_dma_reg_decoder (
    .clk(clk), .rst_n(rst_n), .mainSel(mainSel), .mainWr(mainWr),
    .mainAddr(mainAddr), .mainWdata(mainWdata), .mainRdata(mainRdata),
    .altSel(altSel), .altWr(altWr), .altAddr(altAddr), .altWdata(altWdata),
    .altRdata(altRdata), .chSel(chSel), .chWr(chWr), .chRegOff(chRegOff),
    .chWdata(chWdata), .chRdata(chRdata), .chIrqSet(chIrqSet),
    .chIrqClr(chIrqClr), .irqOut(irqOut), .chEnable(chEnable)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        alt;
    logic        wr;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [15:0] expSel;
    logic        chkRd;
    logic [31:0] expRd;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{1'b0, 1'b0, 12'h000, 32'h0,        16'h0001, 1'b1, 32'hA000_0000}, // R1 R2
    '{1'b0, 1'b0, 12'h3A4, 32'h0,        16'h0008, 1'b1, 32'hA300_00A4}, // R1 R2
    '{1'b0, 1'b1, 12'hE10, 32'h5555_AAAA,16'h4000, 1'b0, 32'h0},         // R1
    '{1'b1, 1'b0, 12'h02C, 32'h0,        16'h8000, 1'b1, 32'hAF00_002C}, // R3
    '{1'b0, 1'b0, 12'hFF0, 32'h0,        16'h0000, 1'b1, 32'h0000_FFFF}, // R4
    '{1'b0, 1'b1, 12'hFF0, 32'hABCD_1234,16'h0000, 1'b0, 32'h0},         // R4
    '{1'b0, 1'b0, 12'hFF0, 32'h0,        16'h0000, 1'b1, 32'h0000_1234}, // R4
    '{1'b0, 1'b0, 12'hF00, 32'h0,        16'h0000, 1'b1, 32'h0},         // R8
    '{1'b0, 1'b1, 12'hFE0, 32'hFFFF_FFFF,16'h0000, 1'b0, 32'h0},         // R5
    '{1'b0, 1'b0, 12'hFE0, 32'h0,        16'h0000, 1'b1, 32'h0},         // R5
    '{1'b0, 1'b0, 12'hF04, 32'h0,        16'h0000, 1'b1, 32'h0}          // R8
  };

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] altKeep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R6 enable", 32'(chEnable), 32'h0000_FFFF);
    check("R6 irq", 32'(irqOut), 32'h0);
    check("R6 mainRdata", mainRdata, 32'h0);
    check("R6 altRdata", altRdata, 32'h0);

    foreach (VECS[k]) begin
      @(negedge clk);
      mainSel = !VECS[k].alt; altSel = VECS[k].alt;
      mainWr  = VECS[k].wr;   altWr  = VECS[k].wr;
      mainAddr = VECS[k].addr; altAddr = VECS[k].addr[7:0];
      mainWdata = VECS[k].wdata; altWdata = VECS[k].wdata;
      #1;
      check($sformatf("R1/R3/R8 sel vec%0d", k), 32'(chSel), 32'(VECS[k].expSel));
      if (VECS[k].expSel != 0) begin
        check($sformatf("R1 off vec%0d", k), 32'(chRegOff), 32'(VECS[k].addr[7:0]));
        check($sformatf("R1 wr vec%0d", k), 32'(chWr), 32'(VECS[k].wr));
        if (VECS[k].wr) check($sformatf("R1 wdata vec%0d", k), chWdata, VECS[k].wdata);
      end
      @(negedge clk);
      mainSel = 0; altSel = 0; mainWr = 0; altWr = 0;
      #1;
      if (VECS[k].chkRd)
        check($sformatf("R2 rdata vec%0d", k),
              VECS[k].alt ? altRdata : mainRdata, VECS[k].expRd);
    end

    // R5 write to status ignored, status still zero on irq lines
    check("R5 irq after status write", 32'(irqOut), 32'h0);

    // R7 set, read back, race, clear
    @(negedge clk); chIrqSet = 16'h0020;
    @(negedge clk); chIrqSet = '0; #1;
    check("R7 set", 32'(irqOut), 32'h0000_0020);
    @(negedge clk); mainSel = 1; mainWr = 0; mainAddr = 12'hFE0;
    @(negedge clk); mainSel = 0; #1;
    check("R5 status read", mainRdata, 32'h0000_0020);
    @(negedge clk); chIrqSet = 16'h0004; chIrqClr = 16'h0004;
    @(negedge clk); chIrqSet = '0; chIrqClr = '0; #1;
    check("R7 set wins", 32'(irqOut), 32'h0000_0024);
    @(negedge clk); chIrqClr = 16'h0020;
    @(negedge clk); chIrqClr = '0; #1;
    check("R7 clear", 32'(irqOut), 32'h0000_0004);

    // R9 collision: main served, alt dropped
    altKeep = altRdata;
    @(negedge clk);
    mainSel = 1; mainWr = 0; mainAddr = 12'h100;
    altSel = 1; altWr = 0; altAddr = 8'h10;
    #1;
    check("R9 sel", 32'(chSel), 32'h0000_0002);
    @(negedge clk); mainSel = 0; altSel = 0; #1;
    check("R9 main rdata", mainRdata, 32'hA100_0000);
    check("R9 alt held", altRdata, altKeep);

    // R3 alt offset F0 reaches channel 15, not the enable word
    @(negedge clk);
    altSel = 1; altWr = 1; altAddr = 8'hF0; altWdata = 32'h0;
    #1;
    check("R3 alt F0 sel", 32'(chSel), 32'h0000_8000);
    check("R3 alt F0 off", 32'(chRegOff), 32'h0000_00F0);
    @(negedge clk); altSel = 0; altWr = 0; #1;
    check("R3 enable untouched", 32'(chEnable), 32'h0000_1234);

    // R8 unmapped write leaves enable alone
    @(negedge clk); mainSel = 1; mainWr = 1; mainAddr = 12'hFF4; mainWdata = 32'h0;
    @(negedge clk); mainSel = 0; mainWr = 0; #1;
    check("R8 unmapped write", 32'(chEnable), 32'h0000_1234);

    finish_run();
  end

endmodule